// File: doc/BRIEF.md
# Serial Avionics Word Receiver

This block turns a bipolar return-to-zero serial line, presented as two digital signals (a ONE line and a ZERO line), into 32-bit words. Each sample clock the active pair is decoded into a symbol. A new valid symbol is one bit, and bits are shifted into a word register with the first bit at index 0. Words are not framed by a fixed count. A word ends when the line has been idle for a set number of sample clocks.

At the end of a word the bit count is checked. A count of exactly 32 delivers the word with a one-cycle load strobe, and odd parity is optionally applied to bit 31. Any other count raises a sticky length-error flag and delivers nothing. A test enable switches the decoder from the line inputs to a pair of digital test inputs. After reset, reception stays disarmed until the first idle gap, so a word caught part-way through is never taken.

Top module: `serial_word_rx`

## Requirements
- R1: While rst_ni is low and just after it is released, word_o is 0, word_load_o is 0 and len_err_o is 0.
- R2: A word of exactly 32 bits followed by a gap gives word_load_o high for exactly one clock. word_o then holds the bits with the first-received bit at index 0 and the last at index 31.
- R3: A sample with only the ONE line high is a 1 bit, and only the ZERO line high is a 0 bit. A sample with both high, like one with neither high, is no bit and counts as idle. A bit is taken when the decoded symbol changes to ONE or ZERO.
- R4: A gap is GAP_LEN (default 17) consecutive idle samples. An idle run of GAP_LEN-1 samples between bits does not end the word.
- R5: With parity_en_i high at the gap, a word with odd parity over its 32 bits is delivered unchanged. A word with even parity is delivered with bit 31 forced to 1.
- R6: With parity_en_i low at the gap, bit 31 of word_o is the 32nd received bit, whatever the parity.
- R7: A gap after any count other than 32 bits sets len_err_o, gives no strobe, and leaves word_o unchanged.
- R8: len_err_o stays set until the next valid 32-bit word is loaded, or until reset.
- R9: After reset is released, bits seen before the first gap are ignored, and that first gap raises neither a strobe nor an error.
- R10: With test_en_i high, test_one_i/test_zero_i feed the decoder and the line inputs have no effect. With test_en_i low, the reverse holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| parity_en_i | input | 1 | Enable odd-parity marking of bit 31 |
| test_en_i | input | 1 | Select the test inputs instead of the line inputs |
| line_one_i | input | 1 | ONE line from the line receiver |
| line_zero_i | input | 1 | ZERO line from the line receiver |
| test_one_i | input | 1 | ONE line, test path |
| test_zero_i | input | 1 | ZERO line, test path |
| word_o | output | 32 | Last delivered word |
| word_load_o | output | 1 | One-cycle strobe when word_o is updated |
| len_err_o | output | 1 | Word length error flag |

## Verification
The receiver is driven with words of 32, 31 and 33 bits, each ended by a gap. This separates delivery from the length-error path, and the valid word afterwards shows the flag clearing. Words of odd and even parity are sent with parity enabled and with it disabled, to tell apart the forced bit 31 from the received bit 31. Further patterns use the longest legal inter-bit idle (GAP_LEN-1 samples) and both-high glitches between bits, which checks gap timing and invalid-symbol handling. Bits are also sent right after reset release, and on the deselected input pair, to confirm they are ignored.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [1:0] {
    SYM_NULL = 2'b00,
    SYM_ONE  = 2'b01,
    SYM_ZERO = 2'b10,
    SYM_BAD  = 2'b11
  } sym_e;
endpackage

// File: rtl/srx_line_front.sv
module srx_line_front
  import srx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic test_en_i,
  input  logic line_one_i,
  input  logic line_zero_i,
  input  logic test_one_i,
  input  logic test_zero_i,
  output logic active_o,
  output logic bit_stb_o,
  output logic bit_val_o
);
  logic one_s, zero_s;
  sym_e sym_d, sym_q, sym_prev_q;

  assign one_s  = test_en_i ? test_one_i  : line_one_i;
  assign zero_s = test_en_i ? test_zero_i : line_zero_i;

  always_comb begin
    unique case ({zero_s, one_s})
      2'b01:   sym_d = SYM_ONE;
      2'b10:   sym_d = SYM_ZERO;
      2'b11:   sym_d = SYM_BAD;
      default: sym_d = SYM_NULL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_q      <= SYM_NULL;
      sym_prev_q <= SYM_NULL;
    end else begin
      sym_q      <= sym_d;
      sym_prev_q <= sym_q;
    end
  end

  assign active_o  = (sym_q == SYM_ONE) || (sym_q == SYM_ZERO);
  // new valid symbol marks a bit
  assign bit_stb_o = active_o && (sym_q != sym_prev_q);
  assign bit_val_o = (sym_q == SYM_ONE);
endmodule

// File: rtl/srx_gap_timer.sv
module srx_gap_timer #(
  parameter int GAP_LEN = 17
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  output logic gap_stb_o
);
  localparam int CNT_W = $clog2(GAP_LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(GAP_LEN - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(GAP_LEN);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (active_i)       cnt_q <= '0;
    else if (cnt_q != FULL)  cnt_q <= cnt_q + 1'b1;
  end

  // fires once per idle run, on its GAP_LEN-th idle sample
  assign gap_stb_o = !active_i && (cnt_q == LAST);
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              armed_i,
  input  logic              bit_stb_i,
  input  logic              bit_val_i,
  input  logic              gap_stb_i,
  output logic [WORD_W-1:0] data_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (gap_stb_i) begin
      cnt_q <= '0;
    end else if (armed_i && bit_stb_i) begin
      sh_q <= {bit_val_i, sh_q[WORD_W-1:1]};
      if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign data_o  = sh_q;
  assign count_o = cnt_q;
endmodule

// File: rtl/srx_word_check.sv
module srx_word_check #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gap_stb_i,
  input  logic              parity_en_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              armed_o,
  output logic [WORD_W-1:0] word_o,
  output logic              load_o,
  output logic              err_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

  logic              armed_q, load_q, err_q, len_ok;
  logic [WORD_W-1:0] word_q, word_d;

  assign len_ok = (count_i == FULL_CNT);

  always_comb begin
    word_d = data_i;
    if (parity_en_i && !(^data_i)) word_d[WORD_W-1] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      load_q  <= 1'b0;
      err_q   <= 1'b0;
      word_q  <= '0;
    end else begin
      load_q <= 1'b0;
      if (gap_stb_i) begin
        armed_q <= 1'b1;
        if (armed_q) begin
          if (len_ok) begin
            word_q <= word_d;
            load_q <= 1'b1;
            err_q  <= 1'b0;
          end else begin
            err_q <= 1'b1;
          end
        end
      end
    end
  end

  assign armed_o = armed_q;
  assign word_o  = word_q;
  assign load_o  = load_q;
  assign err_o   = err_q;
endmodule

// File: rtl/serial_word_rx.sv
module serial_word_rx #(
  parameter int WORD_W  = 32,
  parameter int GAP_LEN = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              parity_en_i,
  input  logic              test_en_i,
  input  logic              line_one_i,
  input  logic              line_zero_i,
  input  logic              test_one_i,
  input  logic              test_zero_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_load_o,
  output logic              len_err_o
);
  localparam int CNT_W = $clog2(WORD_W) + 2;

  logic              active, bit_stb, bit_val, gap_stb, armed;
  logic [WORD_W-1:0] sh_data;
  logic [CNT_W-1:0]  bit_cnt;

  srx_line_front i_front (
    .clk_i, .rst_ni, .test_en_i,
    .line_one_i, .line_zero_i, .test_one_i, .test_zero_i,
    .active_o(active), .bit_stb_o(bit_stb), .bit_val_o(bit_val)
  );

  srx_gap_timer #(.GAP_LEN(GAP_LEN)) i_gap (
    .clk_i, .rst_ni, .active_i(active), .gap_stb_o(gap_stb)
  );

  srx_shifter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) i_shift (
    .clk_i, .rst_ni, .armed_i(armed), .bit_stb_i(bit_stb),
    .bit_val_i(bit_val), .gap_stb_i(gap_stb),
    .data_o(sh_data), .count_o(bit_cnt)
  );

  srx_word_check #(.WORD_W(WORD_W), .CNT_W(CNT_W)) i_check (
    .clk_i, .rst_ni, .gap_stb_i(gap_stb), .parity_en_i,
    .data_i(sh_data), .count_i(bit_cnt), .armed_o(armed),
    .word_o, .load_o(word_load_o), .err_o(len_err_o)
  );
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int WORD_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              parity_en_i,
  input logic              armed_i,
  input logic [WORD_W-1:0] word_o,
  input logic              word_load_o,
  input logic              len_err_o
);
  // R11-style single pulse, R2
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_load_o |=> !word_load_o);

  // R7
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_load_o |-> $stable(word_o));

  // R8
  load_clears_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_load_o |-> !len_err_o);

  // R7
  err_no_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(len_err_o) |-> !word_load_o);

  // R9
  armed_before_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_load_o || len_err_o) |-> armed_i);

  // R5
  parity_mark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_load_o && $past(parity_en_i)) |-> ((^word_o) || word_o[WORD_W-1]));
endmodule

bind serial_word_rx srx_checker #(.WORD_W(WORD_W)) i_srx_checker (
  .clk_i, .rst_ni, .parity_en_i, .armed_i(armed),
  .word_o, .word_load_o, .len_err_o
);

// File: tb/test_serial_word_rx.sv
module test_serial_word_rx;
  localparam int GAP = 17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        par_en = 1'b0, test_en = 1'b0;
  logic        l_one = 1'b0, l_zero = 1'b0, t_one = 1'b0, t_zero = 1'b0;
  logic [31:0] word;
  logic        load, err;

  int checks = 0, fails = 0;
  int loads = 0, run = 0, max_run = 0;
  logic [31:0] last_word = '0;

  always #10 clk = ~clk;

  serial_word_rx i_serial_word_rx (
    .clk_i(clk), .rst_ni(rst_n), .parity_en_i(par_en), .test_en_i(test_en),
    .line_one_i(l_one), .line_zero_i(l_zero), .test_one_i(t_one),
    .test_zero_i(t_zero), .word_o(word), .word_load_o(load), .len_err_o(err)
  );

  // strobe monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (load) begin
      loads++;
      last_word = word;
      run++;
      if (run > max_run) max_run = run;
    end else run = 0;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input bit use_t, input logic one, input logic zero);
    if (use_t) begin t_one = one; t_zero = zero; end
    else begin l_one = one; l_zero = zero; end
  endtask

  // one bit: 2 active samples, optional both-high glitch, then idle
  task automatic send_bit(input bit use_t, input logic v, input int idle, input bit glitch);
    @(negedge clk) drive(use_t, v, ~v);
    @(negedge clk);
    @(negedge clk) drive(use_t, 1'b0, 1'b0);
    if (glitch) begin
      drive(use_t, 1'b1, 1'b1);
      @(negedge clk);
      @(negedge clk) drive(use_t, 1'b0, 1'b0);
    end
    repeat (idle - 1) @(negedge clk);
  endtask

  task automatic send_word(input bit use_t, input logic [63:0] d, input int n,
                           input int idle, input bit glitch);
    for (int i = 0; i < n; i++) send_bit(use_t, d[i], idle, glitch);
    repeat (GAP + 6) @(negedge clk);
  endtask

  function automatic logic [31:0] expect_word(input logic [31:0] d, input bit pe);
    logic [31:0] e = d;
    if (pe && !(^d)) e[31] = 1'b1;
    return e;
  endfunction

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic arm();
    repeat (GAP + 4) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    check("R1 word", word, 32'h0);
    check("R1 load", {31'b0, load}, 32'h0);
    check("R1 err", {31'b0, err}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 err after release", {31'b0, err}, 32'h0);
  endtask

  task automatic t_first_gap();
    int l0;
    l0 = loads;
    // R9: partial bits right after release are dropped
    send_word(1'b0, 64'h3A5, 20, 2, 1'b0);
    check("R9 no load", loads - l0, 0);
    check("R9 no err", {31'b0, err}, 32'h0);
  endtask

  task automatic t_basic(input logic [31:0] d, input bit pe, input string req);
    int l0;
    par_en = pe;
    l0 = loads;
    send_word(1'b0, {32'h0, d}, 32, 2, 1'b0);
    check({req, " one load"}, loads - l0, 1);
    check({req, " word"}, last_word, expect_word(d, pe));
    check({req, " err"}, {31'b0, err}, 32'h0);
  endtask

  task automatic t_len_err(input int n);
    int l0;
    logic [31:0] prev;
    l0 = loads;
    prev = word;
    send_word(1'b0, 64'hFFFF_0000_1234_5678, n, 2, 1'b0);
    check("R7 err set", {31'b0, err}, 32'h1);
    check("R7 no load", loads - l0, 0);
    check("R7 word kept", word, prev);
  endtask

  task automatic t_gap_edge();
    int l0;
    l0 = loads;
    par_en = 1'b0;
    // idle after each bit totals GAP-1 samples
    send_word(1'b0, {32'h0, 32'hC0DE_1357}, 32, GAP - 1, 1'b0);
    check("R4 single word", loads - l0, 1);
    check("R4 word", last_word, 32'hC0DE_1357);
  endtask

  task automatic t_glitch();
    int l0;
    l0 = loads;
    par_en = 1'b0;
    send_word(1'b0, {32'h0, 32'h8765_4321}, 32, 4, 1'b1);
    check("R3 both-high ignored load", loads - l0, 1);
    check("R3 both-high ignored word", last_word, 32'h8765_4321);
  endtask

  task automatic t_test_path();
    int l0;
    par_en = 1'b0;
    test_en = 1'b1;
    l0 = loads;
    send_word(1'b1, {32'h0, 32'h0F0F_A5A5}, 32, 2, 1'b0);
    check("R10 test path load", loads - l0, 1);
    check("R10 test path word", last_word, 32'h0F0F_A5A5);
    l0 = loads;
    send_word(1'b0, {32'h0, 32'h1111_2222}, 32, 2, 1'b0);
    check("R10 line ignored load", loads - l0, 0);
    check("R10 line ignored err", {31'b0, err}, 32'h0);
    check("R10 line ignored word", word, 32'h0F0F_A5A5);
    test_en = 1'b0;
    l0 = loads;
    send_word(1'b1, {32'h0, 32'h3333_4444}, 32, 2, 1'b0);
    check("R10 test ignored load", loads - l0, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_first_gap();
    t_basic(32'h8000_0001, 1'b0, "R2");
    t_basic(32'h0000_0007, 1'b1, "R5 odd");
    t_basic(32'h0000_0003, 1'b1, "R5 even");
    t_basic(32'h0000_0003, 1'b0, "R6 even");
    t_basic(32'h8000_0003, 1'b0, "R6 bit31");
    check("R2 strobe width", max_run, 1);
    t_len_err(31);
    t_basic(32'hDEAD_BEEF, 1'b0, "R8 clear");
    t_len_err(33);
    do_reset();
    @(negedge clk);
    check("R8 reset clears err", {31'b0, err}, 32'h0);
    arm();
    t_gap_edge();
    t_glitch();
    t_test_path();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule